// File: doc/BRIEF.md
# Power Amplifier Gate Bias Regulator

This block regulates the quiescent drain current of a power amplifier by steering the code sent to the gate-voltage converter. A digitised drain-current reading arrives with a one-cycle valid strobe. On each valid reading the block compares it with a programmed target current. If the reading lies outside a programmed tolerance band, the gate code moves one programmed step in the direction that reduces the error. The result is then held between a programmed floor and ceiling. The code width is a parameter: 12 bits suits a converter and 8 bits suits a 256-position potentiometer.

Two paths override the regulation. The first is time-division duplex gating. While the transmit-enable input is low, the gate code is held at zero. On the first transmit cycle it jumps straight to a stored start-up code instead of climbing from zero. The second is overcurrent protection. A reading above a programmed trip level latches a fault that forces the code to zero. The fault stays set until software pulses a clear input.

Top module: `pa_bias_loop`

## Requirements
- R1: After reset, gate_code is 0, code_strobe is 0 and tripped is 0.
- R2: In any cycle where tx_en is 0, gate_code is 0 in the following cycle, and samples that do not trip have no effect.
- R3: In the first cycle with tx_en at 1 after a cycle with it at 0, gate_code becomes start_code limited to [code_min, code_max] in the following cycle. A sample taken in that same cycle has no effect.
- R4: In steady transmit, a valid sample whose absolute distance from setpoint is at most deadband leaves gate_code unchanged.
- R5: In steady transmit, a valid sample below setpoint by more than deadband raises gate_code by step_size. The result is capped at code_max and floored at code_min.
- R6: In steady transmit, a valid sample above setpoint by more than deadband lowers gate_code by step_size. The result is floored at code_min and capped at code_max.
- R7: In steady transmit, with no valid sample and no fault change, gate_code holds its value.
- R8: A valid sample strictly greater than trip_level sets tripped and drives gate_code to 0 on the next cycle. A sample equal to trip_level does not trip.
- R9: tripped stays set until trip_clear is 1. If trip_clear is raised while tx_en is 1, gate_code reloads the limited start_code. If a new trip occurs in the same cycle as trip_clear, the trip wins.
- R10: code_strobe is 1 for exactly those cycles in which gate_code differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | 1 = transmit, 0 = receive (gate off) |
| smp_valid | input | 1 | One-cycle strobe marking a new current reading |
| smp_data | input | SMP_W | Digitised drain current |
| setpoint | input | SMP_W | Target drain current |
| deadband | input | SMP_W | Tolerated error magnitude |
| trip_level | input | SMP_W | Overcurrent threshold (strictly exceeded to trip) |
| trip_clear | input | 1 | Clears a latched overcurrent fault |
| step_size | input | CODE_W | Code change per correction |
| code_min | input | CODE_W | Lowest code in transmit |
| code_max | input | CODE_W | Highest code in transmit |
| start_code | input | CODE_W | Code loaded at the start of transmit |
| gate_code | output | CODE_W | Gate-voltage code to converter |
| code_strobe | output | 1 | Pulses when gate_code changes |
| tripped | output | 1 | Latched overcurrent fault |

## Verification
The hardest situations to reach are the collisions of the override paths with regulation. Examples are a fault clear landing while transmit is already on, a clear and a fresh trip arriving together, and a transmit edge that coincides with a valid sample. The bench reaches these by first running long sweeps of every reading value against several target, band and step settings, which walks the code into both saturation limits. It then issues targeted sequences that place trip, clear and transmit edges on chosen cycles, with a cycle-accurate arithmetic model predicting each output.

// File: rtl/pa_bias_loop.sv
`timescale 1ns/1ps
module pa_bias_loop #(
  parameter int SMP_W  = 12,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic [SMP_W-1:0]  setpoint,
  input  logic [SMP_W-1:0]  deadband,
  input  logic [SMP_W-1:0]  trip_level,
  input  logic              trip_clear,
  input  logic [CODE_W-1:0] step_size,
  input  logic [CODE_W-1:0] code_min,
  input  logic [CODE_W-1:0] code_max,
  input  logic [CODE_W-1:0] start_code,
  output logic [CODE_W-1:0] gate_code,
  output logic              code_strobe,
  output logic              tripped
);
  localparam int EXT_W = CODE_W + 2;

  logic [CODE_W-1:0] code_q, code_d;
  logic trip_q, tx_q, strobe_q;

  wire trip_hit = smp_valid && (smp_data > trip_level);
  wire trip_d   = trip_hit | (trip_q & ~trip_clear);
  wire load     = tx_en & (~tx_q | trip_q);

  wire             below   = smp_data < setpoint;
  wire [SMP_W-1:0] err_mag = below ? (setpoint - smp_data) : (smp_data - setpoint);
  wire             in_band = err_mag <= deadband;

  wire signed [EXT_W-1:0] code_x  = $signed({2'b00, code_q});
  wire signed [EXT_W-1:0] step_x  = $signed({2'b00, step_size});
  wire signed [EXT_W-1:0] moved   = below ? (code_x + step_x) : (code_x - step_x);
  wire signed [EXT_W-1:0] start_x = $signed({2'b00, start_code});
  wire signed [EXT_W-1:0] hi_x    = $signed({2'b00, code_max});
  wire signed [EXT_W-1:0] lo_x    = $signed({2'b00, code_min});

  logic [CODE_W-1:0] moved_c, start_c;

  always_comb begin
    if (moved > hi_x)      moved_c = code_max;
    else if (moved < lo_x) moved_c = code_min;
    else                   moved_c = code_q + (below ? step_size : -step_size);
  end

  always_comb begin
    if (start_x > hi_x)      start_c = code_max;
    else if (start_x < lo_x) start_c = code_min;
    else                     start_c = start_code;
  end

  always_comb begin
    code_d = code_q;
    if (trip_d || !tx_en)          code_d = '0;
    else if (load)                 code_d = start_c;
    else if (smp_valid && !in_band) code_d = moved_c;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q   <= '0;
      trip_q   <= 1'b0;
      tx_q     <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      code_q   <= code_d;
      trip_q   <= trip_d;
      tx_q     <= tx_en;
      strobe_q <= code_d != code_q;
    end
  end

  assign gate_code   = code_q;
  assign code_strobe = strobe_q;
  assign tripped     = trip_q;
endmodule

// File: rtl/pa_bias_loop_chk.sv
`timescale 1ns/1ps
module pa_bias_loop_chk #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic              smp_valid,
  input logic              trip_clear,
  input logic [CODE_W-1:0] gate_code,
  input logic              code_strobe,
  input logic              tripped
);
  assert_rx_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> gate_code == '0);

  assert_fault_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |-> gate_code == '0);

  assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && !trip_clear) |=> tripped);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_en) && !smp_valid && !tripped) |=> $stable(gate_code));

  assert_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    code_strobe == (gate_code != $past(gate_code)));
endmodule

bind pa_bias_loop pa_bias_loop_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .smp_valid(smp_valid),
  .trip_clear(trip_clear), .gate_code(gate_code),
  .code_strobe(code_strobe), .tripped(tripped)
);

// File: tb/sim_pa_bias_loop.sv
`timescale 1ns/1ps
module sim_pa_bias_loop;
  localparam int SW = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, tx_en = 1'b0, smp_valid = 1'b0, trip_clear = 1'b0;
  logic [SW-1:0] smp_data = '0, setpoint = '0, deadband = '0, trip_level = '0;
  logic [CW-1:0] step_size = '0, code_min = '0, code_max = '0, start_code = '0;
  logic [CW-1:0] gate_code;
  logic code_strobe, tripped;

  pa_bias_loop #(.SMP_W(SW), .CODE_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .smp_valid(smp_valid),
    .smp_data(smp_data), .setpoint(setpoint), .deadband(deadband),
    .trip_level(trip_level), .trip_clear(trip_clear), .step_size(step_size),
    .code_min(code_min), .code_max(code_max), .start_code(start_code),
    .gate_code(gate_code), .code_strobe(code_strobe), .tripped(tripped)
  );

  int n_tests = 0, n_fail = 0;
  int m_code = 0;
  bit m_trip = 0, m_txq = 0;
  bit finished = 0;

  function automatic int lim(int x);
    if (x > int'(code_max)) return int'(code_max);
    if (x < int'(code_min)) return int'(code_min);
    return x;
  endfunction

  task automatic cyc();
    string tag;
    int nc, d;
    bit hit, tn;
    hit = smp_valid && (smp_data > trip_level);
    tn  = hit | (m_trip & ~trip_clear);
    if (tn) begin nc = 0; tag = hit ? "R8" : "R9"; end
    else if (!tx_en) begin nc = 0; tag = "R2"; end
    else if (!m_txq || m_trip) begin nc = lim(int'(start_code)); tag = m_trip ? "R9" : "R3"; end
    else if (smp_valid) begin
      d = int'(setpoint) - int'(smp_data);
      if ((d < 0 ? -d : d) <= int'(deadband)) begin nc = m_code; tag = "R4"; end
      else if (d > 0) begin nc = lim(m_code + int'(step_size)); tag = "R5"; end
      else begin nc = lim(m_code - int'(step_size)); tag = "R6"; end
    end else begin nc = m_code; tag = "R7"; end
    @(posedge clk); #1;
    n_tests++;
    if (int'(gate_code) != nc || tripped != tn) begin
      n_fail++;
      $display("FAIL %s: code=%0d trip=%0d expected code=%0d trip=%0d", tag, gate_code, tripped, nc, tn);
    end
    n_tests++;
    if (code_strobe != (nc != m_code)) begin
      n_fail++;
      $display("FAIL R10: strobe=%0d expected %0d", code_strobe, (nc != m_code));
    end
    m_code = nc; m_trip = tn; m_txq = tx_en;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    trip_level = 8'd250; code_min = 8'd20; code_max = 8'd230; start_code = 8'd100;
    repeat (3) @(posedge clk);
    #1;
    n_tests++;
    if (gate_code != 0 || code_strobe != 0 || tripped != 0) begin
      n_fail++;
      $display("FAIL R1: code=%0d strobe=%0d trip=%0d expected 0 0 0", gate_code, code_strobe, tripped);
    end
    rst_n = 1'b1;

    // R2: receive, samples without trip ignored
    setpoint = 8'd128; step_size = 8'd7;
    for (int s = 0; s <= 250; s += 10) begin smp_valid = 1; smp_data = 8'(s); cyc(); end
    smp_valid = 0;

    // R3: start code clamped above, below, inside; sample in same cycle ignored
    foreach (start_code[i]) ;
    for (int k = 0; k < 3; k++) begin
      start_code = (k == 0) ? 8'd245 : (k == 1) ? 8'd5 : 8'd90;
      tx_en = 1; smp_valid = 1; smp_data = 8'd0; cyc();
      smp_valid = 0; cyc();
      tx_en = 0; cyc();
    end

    // R4..R7 sweeps with saturation
    start_code = 8'd100;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < 3; c++) begin
          setpoint   = (a == 0) ? 8'd64 : (a == 1) ? 8'd128 : 8'd200;
          deadband   = (b == 0) ? 8'd0 : 8'd5;
          step_size  = (c == 0) ? 8'd1 : (c == 1) ? 8'd7 : 8'd40;
          tx_en = 1;
          for (int s = 0; s <= 250; s++) begin
            smp_valid = 1; smp_data = 8'(s); cyc();
            if (s % 3 == 0) begin smp_valid = 0; cyc(); end
          end
          for (int s = 250; s >= 0; s -= 3) begin smp_valid = 1; smp_data = 8'(s); cyc(); end
          smp_valid = 0; tx_en = 0; cyc();
        end

    // R8/R9: trip edge, stickiness, clear in transmit, clear vs trip collision
    setpoint = 8'd128; deadband = 8'd2; step_size = 8'd7; tx_en = 1;
    cyc(); cyc();
    smp_valid = 1; smp_data = 8'd250; cyc();
    smp_data = 8'd251; cyc();
    smp_valid = 0; repeat (4) cyc();
    smp_valid = 1; smp_data = 8'd10; cyc(); smp_valid = 0;
    trip_clear = 1; cyc(); trip_clear = 0; cyc();
    smp_valid = 1; smp_data = 8'd255; cyc(); smp_valid = 0; cyc();
    trip_clear = 1; smp_valid = 1; smp_data = 8'd252; cyc();
    smp_valid = 0; cyc();
    trip_clear = 0; cyc();
    tx_en = 0; trip_clear = 1; cyc(); trip_clear = 0; cyc();
    tx_en = 1; cyc(); cyc();
    smp_valid = 1; smp_data = 8'd251; tx_en = 0; cyc(); smp_valid = 0; cyc();
    trip_clear = 1; tx_en = 1; cyc(); trip_clear = 0; cyc();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule